// File: doc/BRIEF.md
# Instruction stream decoder and dispatcher

This block sits at the front of a small self-timed style processor pipeline. It takes 8-bit program words one at a time over a valid/ready handshake. It splits each word into an opcode and a small operand field. When an instruction needs a second word as an address or immediate, the block waits for that word. It then hands the finished instruction to one of four downstream lanes: branch, read, ALU or write. It does not execute anything. It only classifies the instruction, collects its words and forwards it.

Each lane has a one-entry output register with its own valid/ready pair. A lane that stops taking instructions stalls the stream, but only when the next instruction is bound for that lane. A value that the read side sends back returns on a separate handshake. The block re-issues it to the ALU lane as a constant-load instruction. Unassigned opcodes are reported with a one-cycle pulse and are discarded. A halt seals the input until reset.

Top module: `instr_dispatch`

## Requirements
- R1: After a synchronous reset, `lane_valid` is 0000 and `illegal` is 0.
- R2: A dispatched packet is 16 bits. Bits [15:11] hold the opcode, which is bits 7..3 of the first word. Bits [10:8] hold the operand, which is bits 2..0 of the first word. Bits [7:0] hold the second word, or zero for a single-word instruction.
- R3: Opcodes 01001, 01000, 00001, 00010, 00011, 00110, 10001 and 01101 take two words. No lane sees such an instruction until its second word has been accepted.
- R4: Lane index 0 is branch, 1 is read, 2 is ALU and 3 is write. Opcodes 00000, 00001, 00010, 00011, 00100, 01000 and 01001 go to lane 0. Opcodes 00110 and 00111 go to lane 1. Opcodes 01100 and 01101 go to lane 3. Every opcode from 10000 to 11111 goes to lane 2.
- R5: A lane's valid rises in the clock cycle after the final word of its instruction is accepted.
- R6: While a lane's valid is high and its ready is low, that lane's valid and packet stay unchanged. During this time `in_ready` is low for any word that would complete an instruction for that lane.
- R7: An accepted first word whose opcode is 00101, 01010, 01011, 01110 or 01111 raises `illegal` for exactly the next cycle. No lane receives it, and it is accepted even while lanes are stalled.
- R8: Once a halt (opcode 00000) has been accepted, `in_ready` stays low until reset.
- R9: An accepted read-return value D appears on lane 2 as the packet {10001, 000, D}, that is 16'h88DD.
- R10: When a read-return value and a stream instruction both want lane 2 in the same cycle, the read-return value wins. `rdret_ready` follows lane 2 room and `in_ready` stays low for the stream instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Program word offered |
| in_word | input | 8 | Program word |
| in_ready | output | 1 | Program word taken this cycle |
| rdret_valid | input | 1 | Read-return value offered |
| rdret_data | input | 8 | Read-return value |
| rdret_ready | output | 1 | Read-return value taken this cycle |
| lane_valid | output | 4 | Per-lane packet present (0 branch, 1 read, 2 ALU, 3 write) |
| lane_ready | input | 4 | Per-lane consumer ready |
| lane_pkt | output | 64 | Lane l packet at bits [16l+15:16l] |
| illegal | output | 1 | One-cycle pulse for an accepted unassigned opcode |

## Verification
Two things can claim the ALU lane's single register in the same cycle: a read-return value and a stream instruction whose last word is bound for the ALU lane. The bench sets this up on purpose. It fills the ALU lane and keeps it stalled, offers both at once, and then frees the lane. It checks that only the read-return handshake completes, that the constant packet comes out first, and that the held stream instruction follows in the next slot. The random phase raises `rdret_valid` in about one cycle in five, alongside a random stream of words, so the same contention also arises often without being staged. A per-lane expected-packet queue checks the order in which the two sources come out.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int WORD_W  = 8;
  localparam int OP_W    = 5;
  localparam int ARG_W   = WORD_W - OP_W;
  localparam int PKT_W   = 2 * WORD_W;
  localparam int N_LANES = 4;
  localparam int LANE_W  = $clog2(N_LANES);

  typedef enum logic [LANE_W-1:0] {
    LANE_BR  = 2'd0,
    LANE_RD  = 2'd1,
    LANE_ALU = 2'd2,
    LANE_WR  = 2'd3
  } lane_e;

  localparam logic [OP_W-1:0] OP_HALT  = 5'b00000;
  localparam logic [OP_W-1:0] OP_CONST = 5'b10001;

  function automatic logic op_needs_ext(input logic [OP_W-1:0] op);
    case (op)
      5'b01001, 5'b01000, 5'b00001, 5'b00010,
      5'b00011, 5'b00110, 5'b10001, 5'b01101: op_needs_ext = 1'b1;
      default:                                op_needs_ext = 1'b0;
    endcase
  endfunction

  function automatic logic op_unassigned(input logic [OP_W-1:0] op);
    case (op)
      5'b00101, 5'b01010, 5'b01011, 5'b01110, 5'b01111: op_unassigned = 1'b1;
      default:                                           op_unassigned = 1'b0;
    endcase
  endfunction

  function automatic lane_e op_lane(input logic [OP_W-1:0] op);
    case (op)
      5'b00000, 5'b00001, 5'b00010, 5'b00011,
      5'b00100, 5'b01000, 5'b01001:           op_lane = LANE_BR;
      5'b00110, 5'b00111:                     op_lane = LANE_RD;
      5'b01100, 5'b01101:                     op_lane = LANE_WR;
      default:                                op_lane = LANE_ALU;
    endcase
  endfunction
endpackage

// File: rtl/ins_gather.sv
module ins_gather
  import dispatch_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   in_word,
  output logic                in_ready,
  input  logic [N_LANES-1:0]  lane_room,
  output logic                fire,
  output lane_e               fire_lane,
  output logic [PKT_W-1:0]    fire_pkt,
  output logic                illegal,
  output logic                halted,
  output logic                mid
);
  logic [WORD_W-1:0] head_q;
  logic [OP_W-1:0]   cur_op;
  logic              want_ext;
  logic              bad_now;
  logic              accept;

  always_comb begin
    cur_op    = mid ? head_q[WORD_W-1:ARG_W] : in_word[WORD_W-1:ARG_W];
    fire_lane = op_lane(cur_op);
    want_ext  = !mid && op_needs_ext(cur_op);
    bad_now   = !mid && op_unassigned(cur_op);
    in_ready  = !halted && (bad_now || want_ext || lane_room[fire_lane]);
    accept    = in_valid && in_ready;
    fire      = accept && !bad_now && !want_ext;
    fire_pkt  = mid ? {head_q, in_word} : {in_word, {WORD_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mid     <= 1'b0;
      head_q  <= '0;
      illegal <= 1'b0;
      halted  <= 1'b0;
    end else begin
      illegal <= accept && bad_now;
      if (accept) begin
        mid <= want_ext;
        if (want_ext) head_q <= in_word;
      end
      if (fire && !mid && cur_op == OP_HALT) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/lane_slot.sv
module lane_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] dout,
  output logic         room
);
  assign room = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      dout      <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ret_merge.sv
module ret_merge
  import dispatch_pkg::*;
(
  input  logic              rdret_valid,
  input  logic [WORD_W-1:0] rdret_data,
  output logic              rdret_ready,
  input  logic              alu_room,
  output logic              stream_room,
  input  logic              st_load,
  input  logic [PKT_W-1:0]  st_pkt,
  output logic              alu_load,
  output logic [PKT_W-1:0]  alu_pkt
);
  logic ret_take;

  always_comb begin
    rdret_ready = alu_room;
    ret_take    = rdret_valid && alu_room;
    stream_room = alu_room && !rdret_valid;
    alu_load    = ret_take || st_load;
    alu_pkt     = ret_take ? {OP_CONST, {ARG_W{1'b0}}, rdret_data} : st_pkt;
  end
endmodule

// File: rtl/instr_dispatch.sv
module instr_dispatch
  import dispatch_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [7:0]                in_word,
  output logic                      in_ready,
  input  logic                      rdret_valid,
  input  logic [7:0]                rdret_data,
  output logic                      rdret_ready,
  output logic [3:0]                lane_valid,
  input  logic [3:0]                lane_ready,
  output logic [63:0]               lane_pkt,
  output logic                      illegal
);
  logic [N_LANES-1:0] slot_room;
  logic [N_LANES-1:0] gather_room;
  logic               fire;
  lane_e              fire_lane;
  logic [PKT_W-1:0]   fire_pkt;
  logic               halted;
  logic               mid_instr;
  logic               stream_room;
  logic               alu_load;
  logic [PKT_W-1:0]   alu_pkt;

  always_comb begin
    gather_room           = slot_room;
    gather_room[LANE_ALU] = stream_room;
  end

  ins_gather u_gather (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_ready  (in_ready),
    .lane_room (gather_room),
    .fire      (fire),
    .fire_lane (fire_lane),
    .fire_pkt  (fire_pkt),
    .illegal   (illegal),
    .halted    (halted),
    .mid       (mid_instr)
  );

  ret_merge u_merge (
    .rdret_valid (rdret_valid),
    .rdret_data  (rdret_data),
    .rdret_ready (rdret_ready),
    .alu_room    (slot_room[LANE_ALU]),
    .stream_room (stream_room),
    .st_load     (fire && fire_lane == LANE_ALU),
    .st_pkt      (fire_pkt),
    .alu_load    (alu_load),
    .alu_pkt     (alu_pkt)
  );

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic             ld;
    logic [PKT_W-1:0] din;
    if (l == int'(LANE_ALU)) begin : g_alu
      assign ld  = alu_load;
      assign din = alu_pkt;
    end else begin : g_plain
      assign ld  = fire && fire_lane == lane_e'(l);
      assign din = fire_pkt;
    end
    lane_slot #(.W(PKT_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .load      (ld),
      .din       (din),
      .out_ready (lane_ready[l]),
      .out_valid (lane_valid[l]),
      .dout      (lane_pkt[l*PKT_W +: PKT_W]),
      .room      (slot_room[l])
    );
  end
endmodule

// File: rtl/instr_dispatch_chk.sv
module instr_dispatch_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [7:0]  in_word,
  input logic        in_ready,
  input logic        rdret_valid,
  input logic [7:0]  rdret_data,
  input logic        rdret_ready,
  input logic [3:0]  lane_valid,
  input logic [3:0]  lane_ready,
  input logic [63:0] lane_pkt,
  input logic        illegal,
  input logic        mid_instr
);
  logic halt_seen;
  logic [4:0] in_op;
  logic [4:0] br_op, rd_op, wr_op;

  assign in_op = in_word[7:3];
  assign br_op = lane_pkt[15:11];
  assign rd_op = lane_pkt[31:27];
  assign wr_op = lane_pkt[63:59];

  always_ff @(posedge clk) begin
    if (rst) halt_seen <= 1'b0;
    else if (lane_valid[0] && br_op == 5'b00000) halt_seen <= 1'b1;
  end

  for (genvar l = 0; l < 4; l++) begin : g_hold
    p_lane_hold_r6: assert property (@(posedge clk) disable iff (rst)
      lane_valid[l] && !lane_ready[l] |=> lane_valid[l] && $stable(lane_pkt[l*16 +: 16]));
  end

  p_halt_seal_r8: assert property (@(posedge clk) disable iff (rst)
    halt_seen |-> !in_ready);

  p_illegal_src_r7: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(in_valid && in_ready && !mid_instr &&
      (in_op == 5'b00101 || in_op == 5'b01010 || in_op == 5'b01011 ||
       in_op == 5'b01110 || in_op == 5'b01111)));

  p_ret_const_r9: assert property (@(posedge clk) disable iff (rst)
    rdret_valid && rdret_ready |=> lane_valid[2] && lane_pkt[47:32] == {8'h88, $past(rdret_data)});

  p_ret_first_r10: assert property (@(posedge clk) disable iff (rst)
    rdret_valid && !mid_instr && in_word[7] && in_op != 5'b10001 |-> !in_ready);

  p_br_route_r4: assert property (@(posedge clk) disable iff (rst)
    lane_valid[0] |-> (br_op == 5'b00000 || br_op == 5'b00001 || br_op == 5'b00010 ||
                       br_op == 5'b00011 || br_op == 5'b00100 || br_op == 5'b01000 ||
                       br_op == 5'b01001));

  p_rd_route_r4: assert property (@(posedge clk) disable iff (rst)
    lane_valid[1] |-> (rd_op == 5'b00110 || rd_op == 5'b00111));

  p_wr_route_r4: assert property (@(posedge clk) disable iff (rst)
    lane_valid[3] |-> (wr_op == 5'b01100 || wr_op == 5'b01101));

  p_alu_route_r4: assert property (@(posedge clk) disable iff (rst)
    lane_valid[2] |-> lane_pkt[47]);
endmodule

bind instr_dispatch instr_dispatch_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_word     (in_word),
  .in_ready    (in_ready),
  .rdret_valid (rdret_valid),
  .rdret_data  (rdret_data),
  .rdret_ready (rdret_ready),
  .lane_valid  (lane_valid),
  .lane_ready  (lane_ready),
  .lane_pkt    (lane_pkt),
  .illegal     (illegal),
  .mid_instr   (mid_instr)
);

// File: tb/instr_dispatch_test.sv
`timescale 1ns/100ps
module instr_dispatch_test;
  localparam real CLK_NS = 4.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_word = 8'h00;
  logic        in_ready;
  logic        rdret_valid = 1'b0;
  logic [7:0]  rdret_data = 8'h00;
  logic        rdret_ready;
  logic [3:0]  lane_valid;
  logic [3:0]  lane_ready = 4'h0;
  logic [63:0] lane_pkt;
  logic        illegal;

  int n_chk = 0;
  int n_err = 0;

  logic [15:0] expq [4][$];
  bit          have = 1'b0;
  logic [7:0]  head = 8'h00;
  logic        exp_ill = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  instr_dispatch uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .rdret_valid(rdret_valid), .rdret_data(rdret_data), .rdret_ready(rdret_ready),
    .lane_valid(lane_valid), .lane_ready(lane_ready), .lane_pkt(lane_pkt), .illegal(illegal)
  );

  function automatic bit b_two(input logic [4:0] op);
    return op inside {5'b01001, 5'b01000, 5'b00001, 5'b00010, 5'b00011, 5'b00110, 5'b10001, 5'b01101};
  endfunction

  function automatic bit b_bad(input logic [4:0] op);
    return op inside {5'b00101, 5'b01010, 5'b01011, 5'b01110, 5'b01111};
  endfunction

  function automatic int b_lane(input logic [4:0] op);
    if (op inside {5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100, 5'b01000, 5'b01001}) return 0;
    if (op inside {5'b00110, 5'b00111}) return 1;
    if (op inside {5'b01100, 5'b01101}) return 3;
    return 2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic drive_word(input logic [7:0] w);
    @(negedge clk); in_valid = 1'b1; in_word = w; #0.5;
    while (!in_ready) begin @(negedge clk); #0.5; end
    @(posedge clk); #0.5; in_valid = 1'b0;
  endtask

  task automatic step(input bit rnd);
    logic [4:0]  op;
    logic [15:0] e;
    @(negedge clk);
    chk("R7 illegal pulse", {31'd0, illegal}, {31'd0, exp_ill});
    exp_ill = 1'b0;
    if (rnd) begin
      in_valid    = ($urandom % 4) != 0;
      in_word     = {5'($urandom_range(31, 1)), 3'($urandom)};
      if (have) in_word = 8'($urandom);
      rdret_valid = ($urandom % 5) == 0;
      rdret_data  = 8'($urandom);
      for (int l = 0; l < 4; l++) lane_ready[l] = ($urandom % 10) < 7;
    end else begin
      in_valid = have; in_word = 8'h00; rdret_valid = 1'b0; lane_ready = 4'hF;
    end
    #1;
    for (int l = 0; l < 4; l++) begin
      if (lane_valid[l] && lane_ready[l]) begin
        if (expq[l].size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R4 lane %0d: actual %h expected none", l, lane_pkt[l*16 +: 16]);
        end else begin
          e = expq[l].pop_front();
          chk(e[15:11] == 5'b10001 ? "R9 R3 lane packet" : "R2 R4 lane packet",
              {16'd0, lane_pkt[l*16 +: 16]}, {16'd0, e});
        end
      end
    end
    if (rdret_valid && rdret_ready) expq[2].push_back({8'h88, rdret_data});
    if (in_valid && in_ready) begin
      if (have) begin
        expq[b_lane(head[7:3])].push_back({head, in_word});
        have = 1'b0;
      end else begin
        op = in_word[7:3];
        if (b_bad(op)) exp_ill = 1'b1;
        else if (b_two(op)) begin have = 1'b1; head = in_word; end
        else expq[b_lane(op)].push_back({in_word, 8'h00});
      end
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 lane_valid after reset", {28'd0, lane_valid}, 32'h0);
    chk("R1 illegal after reset", {31'd0, illegal}, 32'h0);

    // R5 single-word latency, R2 layout
    drive_word(8'h85);
    @(negedge clk);
    chk("R5 alu valid next cycle", {28'd0, lane_valid}, 32'h4);
    chk("R2 alu packet", {16'd0, lane_pkt[47:32]}, 32'h8500);
    // R6 hold under stall
    repeat (2) @(negedge clk);
    chk("R6 alu held valid", {31'd0, lane_valid[2]}, 32'h1);
    chk("R6 alu held packet", {16'd0, lane_pkt[47:32]}, 32'h8500);
    in_valid = 1'b1; in_word = 8'hA3; #0.5;
    chk("R6 in_ready low for stalled lane", {31'd0, in_ready}, 32'h0);
    in_valid = 1'b0;

    // R7 illegal word accepted despite stall
    drive_word(8'h2F);
    @(negedge clk);
    chk("R7 illegal pulse", {31'd0, illegal}, 32'h1);
    chk("R7 no lane got illegal", {28'd0, lane_valid}, 32'h4);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'd0, illegal}, 32'h0);

    // R3 two-word jump to branch lane
    drive_word(8'h0B);
    @(negedge clk);
    chk("R3 no dispatch after first word", {31'd0, lane_valid[0]}, 32'h0);
    drive_word(8'h3C);
    @(negedge clk);
    chk("R3 branch valid after second word", {31'd0, lane_valid[0]}, 32'h1);
    chk("R3 R4 branch packet", {16'd0, lane_pkt[15:0]}, 32'h0B3C);

    // R10 contention for the ALU slot
    @(negedge clk);
    rdret_valid = 1'b1; rdret_data = 8'h77; in_valid = 1'b1; in_word = 8'hA3; #0.5;
    chk("R10 rdret_ready follows stalled alu", {31'd0, rdret_ready}, 32'h0);
    lane_ready[2] = 1'b1; #0.5;
    chk("R10 rdret_ready with room", {31'd0, rdret_ready}, 32'h1);
    chk("R10 stream held", {31'd0, in_ready}, 32'h0);
    @(posedge clk); #0.5; rdret_valid = 1'b0;
    @(negedge clk);
    chk("R9 const packet", {16'd0, lane_pkt[47:32]}, 32'h8877);
    chk("R10 stream released", {31'd0, in_ready}, 32'h1);
    @(posedge clk); #0.5; in_valid = 1'b0; lane_ready = 4'h0;
    @(negedge clk);
    chk("R10 stream follows const", {16'd0, lane_pkt[47:32]}, 32'hA300);

    lane_ready = 4'hF;
    repeat (2) @(negedge clk);
    chk("R6 lanes drain", {28'd0, lane_valid}, 32'h0);

    // random phase against the bench model
    repeat (3000) step(1'b1);
    repeat (6) step(1'b0);
    for (int l = 0; l < 4; l++)
      chk("R4 expected queue empty", expq[l].size(), 32'd0);

    // R8 halt seals the input
    lane_ready = 4'hF;
    drive_word(8'h00);
    @(negedge clk);
    chk("R8 halt in branch lane", {31'd0, lane_valid[0]}, 32'h1);
    chk("R8 halt packet", {16'd0, lane_pkt[15:0]}, 32'h0000);
    in_valid = 1'b1; in_word = 8'h85;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #0.5;
      chk("R8 in_ready low after halt", {31'd0, in_ready}, 32'h0);
      chk("R8 nothing dispatched after halt", {31'd0, lane_valid[2]}, 32'h0);
    end
    in_valid = 1'b0;

    summary();
    $finish;
  end
endmodule